// File: doc/BRIEF.md
# Machine-Cycle Timer and Event Counter

This block is one 16-bit counting channel in the style of a small microcontroller timer. It runs on the oscillator clock and divides that clock by a parameter, six by default, to make a one-clock strobe. Each strobe marks the end of one machine cycle. A mode byte chooses what the channel counts.

In timer mode the channel counts machine cycles. In counter mode it counts falling edges on an external pin. The pin is synchronized first. It is then sampled once per machine cycle, and a high sample followed by a low sample is one event.

A two-bit field picks the count width:
- 13-bit prescaled counting.
- Full 16-bit counting.
- 8-bit counting with auto-reload.
- A frozen state.

Software can load the high and low count bytes at any time and can read the count back. A sticky overflow flag records each wrap or reload.

Top module: `mcyc_timer`

## Requirements
- R1: The `tick` output is high for exactly one clock in every 6 clocks (CYCLE_DIV). The first tick occurs in the 6th clock cycle after reset is released.
- R2: Timer mode is `mode_byte[2]`=0. With `run_en` high, the count advances by one at each clock edge where `tick` is high, and at no other edge.
- R3: Counter mode is `mode_byte[2]`=1. The synchronized pin is sampled at each tick. A high sample followed by a low sample is one count. That count becomes visible at the tick after the one that took the low sample.
- R4: The pin must hold each level for at least two machine cycles per full period to be counted reliably. A pin toggling every 3 clocks gives fewer counts than edges. A pin held 6 clocks high and 6 clocks low gives one count per period.
- R5: A low pulse of 6 clocks is counted once, whatever its phase relative to the tick.
- R6: Mode field `mode_byte[1:0]`=00 is 13-bit counting. `count_q[4:0]` is the prescaler and carries into `count_q[15:8]`. `count_q[7:5]` is held. Overflow occurs when the count steps from 0xFF1F-form (all 13 bits set) to zero.
- R7: Mode field 01 is 16-bit counting. A step from 0xFFFF gives 0x0000 and overflow.
- R8: Mode field 10 counts in `count_q[7:0]` only. A step from 0xFF reloads the low byte from `count_q[15:8]` and signals overflow. The high byte is unchanged.
- R9: Mode field 11 holds the count; no count and no overflow occur.
- R10: `ovf_flag` is set at the same clock edge where the count wraps or reloads. It stays set until a clock with `ovf_clr` high. If a set and a clear occur together, the set wins.
- R11: While `run_en` is low, the count does not advance in either mode.
- R12: A load (`ld_hi_en`, `ld_lo_en`) replaces the selected byte at the next clock edge. A load takes priority over an increment at the same edge, and that increment is dropped.
- R13: After reset `count_q` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counting enable |
| cnt_pin | input | 1 | External event input, asynchronous |
| mode_byte | input | 8 | Bit 2 selects timer (0) or counter (1); bits 1:0 select the mode; other bits unused |
| ld_hi_en | input | 1 | Load strobe for the high count byte |
| ld_hi_val | input | 8 | High byte load value |
| ld_lo_en | input | 1 | Load strobe for the low count byte |
| ld_lo_val | input | 8 | Low byte load value |
| ovf_clr | input | 1 | Clear for the overflow flag |
| count_q | output | 16 | Current count, high byte in bits 15:8 |
| ovf_flag | output | 1 | Sticky overflow flag |
| tick | output | 1 | Machine-cycle strobe |

## Verification
The assertions check the following on every cycle:
- The tick spacing.
- That the count stays still between ticks, while the channel is stopped, and in the frozen mode.
- The single-step rule in 16-bit timer mode.
- Byte-load priority.
- The overflow flag's set, hold and clear rules.

The bench scenarios are the only evidence for the rest:
- Counter-mode behaviour: the exact tick at which a detected fall appears, the aliasing of a pin that toggles too fast, and capture of one-machine-cycle pulses at different phases.
- The carry and wrap values of the 13-bit mode and the reload value of the 8-bit mode.

// File: rtl/mcyc_timer_pkg.sv
package mcyc_timer_pkg;

   typedef enum logic [1:0] {
      CM_W13     = 2'b00,
      CM_W16     = 2'b01,
      CM_RELOAD8 = 2'b10,
      CM_HOLD    = 2'b11
   } cnt_mode_e;

   localparam int SEL_BIT = 2;

endpackage

// File: rtl/mcyc_strobe_gen.sv
module mcyc_strobe_gen #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] div_cnt;

   if (DIV < 2) begin : g_bad_div
      $error("mcyc_strobe_gen: DIV must be at least 2");
   end

   assign tick = (div_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         div_cnt <= '0;
      else if (tick)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end
endmodule

// File: rtl/pin_fall_sampler.sv
module pin_fall_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   input  logic tick,
   output logic fall
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp_prev;
   logic                   samp_cur;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_fall_sampler: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         sync_q[0] <= 1'b0;
      else
         sync_q[0] <= pin;
   end

   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (rst)
            sync_q[i] <= 1'b0;
         else
            sync_q[i] <= sync_q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         samp_prev <= 1'b0;
         samp_cur  <= 1'b0;
      end else if (tick) begin
         samp_prev <= samp_cur;
         samp_cur  <= sync_q[SYNC_STAGES-1];
      end
   end

   assign fall = samp_prev & ~samp_cur;
endmodule

// File: rtl/count_core.sv
module count_core
   import mcyc_timer_pkg::*;
#(
   parameter int HI_W  = 8,
   parameter int LO_W  = 8,
   parameter int PRE_W = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            inc,
   input  cnt_mode_e       mode,
   input  logic            ld_hi_en,
   input  logic [HI_W-1:0] ld_hi_val,
   input  logic            ld_lo_en,
   input  logic [LO_W-1:0] ld_lo_val,
   output logic [HI_W-1:0] hi_q,
   output logic [LO_W-1:0] lo_q,
   output logic            wrap
);
   if (PRE_W < 1 || PRE_W > LO_W) begin : g_bad_pre
      $error("count_core: PRE_W must lie in 1..LO_W");
   end
   if (HI_W != LO_W) begin : g_bad_reload
      $error("count_core: reload mode needs HI_W == LO_W");
   end

   logic [HI_W-1:0] hi_n;
   logic [LO_W-1:0] lo_n;

   always_comb begin
      hi_n = hi_q;
      lo_n = lo_q;
      wrap = 1'b0;
      if (ld_hi_en || ld_lo_en) begin
         if (ld_hi_en) hi_n = ld_hi_val;
         if (ld_lo_en) lo_n = ld_lo_val;
      end else if (inc) begin
         case (mode)
            CM_W13: begin
               if (&lo_q[PRE_W-1:0]) begin
                  lo_n[PRE_W-1:0] = '0;
                  hi_n            = hi_q + 1'b1;
                  wrap            = &hi_q;
               end else begin
                  lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
               end
            end
            CM_W16: begin
               {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
               wrap         = &{hi_q, lo_q};
            end
            CM_RELOAD8: begin
               if (&lo_q) begin
                  lo_n = hi_q;
                  wrap = 1'b1;
               end else begin
                  lo_n = lo_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end
endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer
   import mcyc_timer_pkg::*;
#(
   parameter int CYCLE_DIV   = 6,
   parameter int SYNC_STAGES = 2,
   parameter int HI_W        = 8,
   parameter int LO_W        = 8,
   parameter int PRE_W       = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 run_en,
   input  logic                 cnt_pin,
   input  logic [7:0]           mode_byte,
   input  logic                 ld_hi_en,
   input  logic [HI_W-1:0]      ld_hi_val,
   input  logic                 ld_lo_en,
   input  logic [LO_W-1:0]      ld_lo_val,
   input  logic                 ovf_clr,
   output logic [HI_W+LO_W-1:0] count_q,
   output logic                 ovf_flag,
   output logic                 tick
);
   logic            fall;
   logic            inc;
   logic            wrap;
   logic            sel_counter;
   logic            mode_unused;
   cnt_mode_e       mode;
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   assign sel_counter = mode_byte[SEL_BIT];
   assign mode        = cnt_mode_e'(mode_byte[1:0]);
   assign mode_unused = ^mode_byte[7:3];

   mcyc_strobe_gen #(.DIV(CYCLE_DIV)) u_strobe (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   pin_fall_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk  (clk),
      .rst  (rst),
      .pin  (cnt_pin),
      .tick (tick),
      .fall (fall)
   );

   assign inc = run_en && tick && (sel_counter ? fall : 1'b1);

   count_core #(.HI_W(HI_W), .LO_W(LO_W), .PRE_W(PRE_W)) u_core (
      .clk       (clk),
      .rst       (rst),
      .inc       (inc),
      .mode      (mode),
      .ld_hi_en  (ld_hi_en),
      .ld_hi_val (ld_hi_val),
      .ld_lo_en  (ld_lo_en),
      .ld_lo_val (ld_lo_val),
      .hi_q      (hi_q),
      .lo_q      (lo_q),
      .wrap      (wrap)
   );

   assign count_q = {hi_q, lo_q};

   always_ff @(posedge clk) begin
      if (rst)
         ovf_flag <= 1'b0;
      else if (wrap)
         ovf_flag <= 1'b1;
      else if (ovf_clr)
         ovf_flag <= 1'b0;
   end
endmodule

// File: rtl/mcyc_timer_chk.sv
module mcyc_timer_chk #(
   parameter int CYCLE_DIV = 6,
   parameter int CW        = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          run_en,
   input logic [7:0]    mode_byte,
   input logic          ld_hi_en,
   input logic [7:0]    ld_hi_val,
   input logic          ld_lo_en,
   input logic [7:0]    ld_lo_val,
   input logic          ovf_clr,
   input logic [CW-1:0] count_q,
   input logic          ovf_flag,
   input logic          tick
);
   logic [31:0] gap;

   always_ff @(posedge clk) begin
      if (rst || tick)
         gap <= '0;
      else
         gap <= gap + 1'b1;
   end

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      tick |-> (gap == 32'(CYCLE_DIV - 1)));
   // R1
   tick_due_chk: assert property (@(posedge clk) disable iff (rst)
      (gap == 32'(CYCLE_DIV - 1)) |-> tick);
   // R2
   between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick && !ld_hi_en && !ld_lo_en) |=> $stable(count_q));
   // R11
   stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_en && !ld_hi_en && !ld_lo_en) |=> $stable(count_q));
   // R7
   w16_step_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && run_en && !mode_byte[2] && mode_byte[1:0] == 2'b01
       && !ld_hi_en && !ld_lo_en) |=> (count_q == $past(count_q) + 16'd1));
   // R9
   frozen_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_byte[1:0] == 2'b11 && !ld_hi_en && !ld_lo_en) |=> $stable(count_q));
   // R12
   lo_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_lo_en |=> (count_q[7:0] == $past(ld_lo_val)));
   // R12
   hi_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_hi_en |=> (count_q[CW-1:8] == $past(ld_hi_val)));
   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (!ovf_flag && !tick) |=> !ovf_flag);
   // R10
   ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_clr && !tick) |=> !ovf_flag);
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind mcyc_timer mcyc_timer_chk #(.CYCLE_DIV(CYCLE_DIV), .CW(HI_W + LO_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .run_en    (run_en),
   .mode_byte (mode_byte),
   .ld_hi_en  (ld_hi_en),
   .ld_hi_val (ld_hi_val),
   .ld_lo_en  (ld_lo_en),
   .ld_lo_val (ld_lo_val),
   .ovf_clr   (ovf_clr),
   .count_q   (count_q),
   .ovf_flag  (ovf_flag),
   .tick      (tick)
);

// File: tb/tb_mcyc_timer.sv
module tb_mcyc_timer;
   logic        clk = 1'b0;
   logic        rst;
   logic        run_en;
   logic        cnt_pin;
   logic [7:0]  mode_byte;
   logic        ld_hi_en;
   logic [7:0]  ld_hi_val;
   logic        ld_lo_en;
   logic [7:0]  ld_lo_val;
   logic        ovf_clr;
   logic [15:0] count_q;
   logic        ovf_flag;
   logic        tick;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      string       tag;
      logic [15:0] cnt;
      logic        ovf;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   mcyc_timer dut (
      .clk(clk), .rst(rst), .run_en(run_en), .cnt_pin(cnt_pin),
      .mode_byte(mode_byte), .ld_hi_en(ld_hi_en), .ld_hi_val(ld_hi_val),
      .ld_lo_en(ld_lo_en), .ld_lo_val(ld_lo_val), .ovf_clr(ovf_clr),
      .count_q(count_q), .ovf_flag(ovf_flag), .tick(tick)
   );

   task automatic expect_state(input string tag, input logic [15:0] c, input logic o);
      exp_t e;
      e.tag = tag;
      e.cnt = c;
      e.ovf = o;
      sb_q.push_back(e);
   endtask

   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (count_q !== e.cnt || ovf_flag !== e.ovf) begin
            errors++;
            $display("FAIL %s: count=%h ovf=%b expected count=%h ovf=%b",
                     e.tag, count_q, ovf_flag, e.cnt, e.ovf);
         end
      end
   end

   task automatic check_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic next_tick();
      @(negedge clk);
      while (!tick) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) next_tick();
   endtask

   task automatic load(input logic [7:0] h, input logic [7:0] l);
      ld_hi_en = 1'b1; ld_hi_val = h;
      ld_lo_en = 1'b1; ld_lo_val = l;
      @(posedge clk); #1;
      ld_hi_en = 1'b0; ld_lo_en = 1'b0;
   endtask

   task automatic clear_ovf();
      ovf_clr = 1'b1;
      @(posedge clk); #1;
      ovf_clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      int n;
      rst = 1'b1; run_en = 1'b0; cnt_pin = 1'b1; mode_byte = 8'h01;
      ld_hi_en = 1'b0; ld_hi_val = 8'h00; ld_lo_en = 1'b0; ld_lo_val = 8'h00;
      ovf_clr = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      expect_state("R13 reset state", 16'h0000, 1'b0);

      // R1: tick spacing and width
      @(negedge clk);
      while (!tick) @(negedge clk);
      @(negedge clk);
      check_int("R1 tick width", int'(tick), 0);
      n = 1;
      while (!tick) begin @(negedge clk); n++; end
      check_int("R1 tick period", n, 6);
      @(posedge clk); #1;

      // R7 / R2 / R10: 16-bit timer
      load(8'hFF, 8'hFE);
      run_en = 1'b1;
      next_tick(); expect_state("R2 timer step", 16'hFFFF, 1'b0);
      next_tick(); expect_state("R7 16-bit wrap", 16'h0000, 1'b1);
      next_tick(); expect_state("R10 flag sticky", 16'h0001, 1'b1);
      ticks(3);    expect_state("R2 one per tick", 16'h0004, 1'b1);
      repeat (3) @(posedge clk); #1;
      expect_state("R2 stable between ticks", 16'h0004, 1'b1);
      clear_ovf(); expect_state("R10 flag clear", 16'h0004, 1'b0);

      // R11: stop
      run_en = 1'b0;
      ticks(3); expect_state("R11 stopped timer", 16'h0004, 1'b0);

      // R12: load on a tick edge wins
      run_en = 1'b1;
      next_tick(); expect_state("R12 pre-load step", 16'h0005, 1'b0);
      repeat (5) @(posedge clk); #1;
      ld_lo_en = 1'b1; ld_lo_val = 8'h55;
      @(posedge clk); #1;
      ld_lo_en = 1'b0;
      expect_state("R12 load beats increment", 16'h0055, 1'b0);
      next_tick(); expect_state("R12 count after load", 16'h0056, 1'b0);

      // R6: 13-bit mode
      run_en = 1'b0; mode_byte = 8'h00;
      load(8'h12, 8'hFF);
      run_en = 1'b1;
      next_tick(); expect_state("R6 prescaler carry", 16'h13E0, 1'b0);
      load(8'hFF, 8'h1E);
      next_tick(); expect_state("R6 prescaler step", 16'hFF1F, 1'b0);
      next_tick(); expect_state("R6 13-bit wrap", 16'h0000, 1'b1);

      // R8: reload mode
      run_en = 1'b0; mode_byte = 8'h02;
      load(8'h80, 8'hFE);
      clear_ovf();
      run_en = 1'b1;
      next_tick(); expect_state("R8 low byte step", 16'h80FF, 1'b0);
      next_tick(); expect_state("R8 reload", 16'h8080, 1'b1);
      next_tick(); expect_state("R8 after reload", 16'h8081, 1'b1);

      // R9: frozen
      mode_byte = 8'h03;
      ticks(3); expect_state("R9 frozen mode", 16'h8081, 1'b1);

      // Counter mode, 16-bit
      mode_byte = 8'h05;
      clear_ovf();
      load(8'h00, 8'h00);
      cnt_pin = 1'b1;
      ticks(2); expect_state("R3 idle high pin", 16'h0000, 1'b0);

      // R3: detection latency
      cnt_pin = 1'b0;
      next_tick(); expect_state("R3 low sampled, not yet counted", 16'h0000, 1'b0);
      next_tick(); expect_state("R3 count lands next tick", 16'h0001, 1'b0);
      cnt_pin = 1'b1;
      ticks(2); expect_state("R3 rising edge ignored", 16'h0001, 1'b0);

      // R5: 6-clock low pulse, two phases
      cnt_pin = 1'b0;
      repeat (6) @(posedge clk); #1;
      cnt_pin = 1'b1;
      ticks(3); expect_state("R5 short pulse phase 0", 16'h0002, 1'b0);
      repeat (2) @(posedge clk); #1;
      cnt_pin = 1'b0;
      repeat (6) @(posedge clk); #1;
      cnt_pin = 1'b1;
      ticks(3); expect_state("R5 short pulse phase 2", 16'h0003, 1'b0);

      // R4: too fast vs. maximum rate
      for (int i = 0; i < 16; i++) begin
         cnt_pin = ~cnt_pin;
         repeat (3) @(posedge clk); #1;
      end
      cnt_pin = 1'b1;
      ticks(2); expect_state("R4 toggling too fast", 16'h0003, 1'b0);
      for (int i = 0; i < 4; i++) begin
         cnt_pin = 1'b0;
         repeat (6) @(posedge clk); #1;
         cnt_pin = 1'b1;
         repeat (6) @(posedge clk); #1;
      end
      ticks(2); expect_state("R4 max rate counts all", 16'h0007, 1'b0);

      // R11: counter stopped
      run_en = 1'b0;
      cnt_pin = 1'b0;
      ticks(2);
      cnt_pin = 1'b1;
      ticks(3); expect_state("R11 stopped counter", 16'h0007, 1'b0);

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule